// File: doc/BRIEF.md
# Paged Window Address Translator

This block sits between a host-facing 32-bit memory-mapped slave port and a wider internal register bus. The host sees a small aperture of four windows, each 512 KiB wide. The block picks the window number out of the host address, looks up which internal page that window currently points at, and glues the page onto the untouched 19-bit offset. The result is a 25-bit internal register address.

Window 0 is wired to internal page 0 for good. Windows 1, 2 and 3 each follow a 6-bit page field held in one packed mapping register. That register also carries a global enable bit. It lives inside window 0 at byte offset 0x310C and is served locally. The host can read it back to flush a remap before it uses the window again.

Each host transaction is a single valid/ready request followed by exactly one response. Only one transaction is in flight at a time.

Top module: `pgwin_xlate`

## Requirements
- R1: After reset the mapping register reads 0x00000000, `h_req_ready` is 1, and `i_req_valid` and `h_rsp_valid` are 0.
- R2: A host access whose address bits 20:19 equal 0 is forwarded with internal page 0, whatever the mapping register holds. The one exception is the mapping register itself.
- R3: The mapping register's enable is bit 30. While it is 1, window w (w = 1..3) uses the page held in mapping register bits 6*(w-1)+5 down to 6*(w-1): window 1 uses bits 5:0, window 2 bits 11:6, and window 3 bits 17:12.
- R4: While the enable bit 30 is 0, windows 1 to 3 also forward with page 0.
- R5: The internal address is {page[5:0], host address[18:0]}. Host address bits 31:21 have no effect on the internal address.
- R6: A host access to window 0 at offset 0x310C reaches the mapping register and is never forwarded. Only bits 30 and 17:0 are stored. All other bits read as 0, and the response comes one cycle after acceptance.
- R7: A forwarded request appears on `i_req_valid` in the cycle after the host request is accepted. It is held with a stable address, data and direction until `i_req_ready`.
- R8: For a forwarded access, `h_rsp_valid` and `h_rsp_rdata` follow `i_rsp_valid` and `i_rsp_rdata` in the same cycle.
- R9: `h_req_ready` stays 0 from the acceptance of a request until its response has been given.
- R10: A new mapping value applies to the first host access accepted after the write's response. The translated address of an accepted access stays fixed while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request accepted when high with valid |
| h_req_write | input | 1 | 1 = write, 0 = read |
| h_req_addr | input | 32 | Host aperture byte address |
| h_req_wdata | input | 32 | Host write data |
| h_rsp_valid | output | 1 | Host response valid (one beat) |
| h_rsp_rdata | output | 32 | Host read data |
| i_req_valid | output | 1 | Internal request valid |
| i_req_ready | input | 1 | Internal request accepted |
| i_req_write | output | 1 | Internal request direction |
| i_req_addr | output | 25 | Internal register address {page, offset} |
| i_req_wdata | output | 32 | Internal write data |
| i_rsp_valid | input | 1 | Internal response valid |
| i_rsp_rdata | input | 32 | Internal read data |

## Verification
A corrupted page field or enable bit shows up on `i_req_addr` bits 24:19 in the very request that uses the affected window. It also shows up in the read-back of the mapping register one cycle after that read is accepted. A latched address that drifts while the internal side stalls would be seen as a changed `i_req_addr` at the handshake. A stuck state machine shows as a missing or duplicated `h_rsp_valid` beat, or as `h_req_ready` rising early, within the next transaction.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
    localparam int DATA_W   = 32;
    localparam int HADDR_W  = 32;
    localparam int PAGE_W   = 6;
    localparam int OFS_W    = 19;
    localparam int WIN_W    = 2;
    localparam int NWIN     = 1 << WIN_W;
    localparam int NMAP     = NWIN - 1;
    localparam int IADDR_W  = PAGE_W + OFS_W;
    localparam int EN_BIT   = 30;
    localparam logic [OFS_W-1:0] MAPREG_OFS = OFS_W'(32'h310C);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_LOCAL = 2'd3
    } xl_state_e;

    typedef struct packed {
        xl_state_e            st;
        logic                 wr;
        logic [IADDR_W-1:0]   addr;
        logic [DATA_W-1:0]    wdata;
    } xl_regs_s;

    typedef struct packed {
        logic                     en;
        logic [NMAP*PAGE_W-1:0]   pages;
    } map_regs_s;
endpackage

// File: rtl/pgwin_map_reg.sv
module pgwin_map_reg
    import pgwin_pkg::*;
#(
    parameter int P_NMAP   = NMAP,
    parameter int P_PAGE_W = PAGE_W,
    parameter int P_EN_BIT = EN_BIT,
    parameter int P_DATA_W = DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [P_DATA_W-1:0]        wdata,
    output logic [P_DATA_W-1:0]        rdata,
    output logic                       map_en,
    output logic [P_NMAP*P_PAGE_W-1:0] map_pages
);
    localparam int FIELD_W = P_NMAP * P_PAGE_W;

    logic                 en_d, en_q;
    logic [FIELD_W-1:0]   pg_d, pg_q;

    always_comb begin
        en_d = en_q;
        pg_d = pg_q;
        if (wr_en) begin
            en_d = wdata[P_EN_BIT];
            pg_d = wdata[FIELD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            pg_q <= '0;
        end else begin
            en_q <= en_d;
            pg_q <= pg_d;
        end
    end

    always_comb begin
        rdata              = '0;
        rdata[FIELD_W-1:0] = pg_q;
        rdata[P_EN_BIT]    = en_q;
    end

    assign map_en    = en_q;
    assign map_pages = pg_q;

    // R6: stored state changes only through a write strobe
    a_r6_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(en_q) && $stable(pg_q)));
endmodule

// File: rtl/pgwin_page_map.sv
module pgwin_page_map
    import pgwin_pkg::*;
#(
    parameter int P_WIN_W  = WIN_W,
    parameter int P_PAGE_W = PAGE_W
) (
    input  logic                                  map_en,
    input  logic [((1<<P_WIN_W)-1)*P_PAGE_W-1:0]  map_pages,
    input  logic [P_WIN_W-1:0]                    win,
    output logic [P_PAGE_W-1:0]                   page
);
    localparam int P_NWIN = 1 << P_WIN_W;

    logic [P_PAGE_W-1:0] tbl [P_NWIN];

    assign tbl[0] = '0;

    for (genvar g = 1; g < P_NWIN; g++) begin : g_win
        assign tbl[g] = map_en ? map_pages[(g-1)*P_PAGE_W +: P_PAGE_W] : '0;
    end

    assign page = tbl[win];
endmodule

// File: rtl/pgwin_xlate.sv
module pgwin_xlate
    import pgwin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 h_req_valid,
    output logic                 h_req_ready,
    input  logic                 h_req_write,
    input  logic [HADDR_W-1:0]   h_req_addr,
    input  logic [DATA_W-1:0]    h_req_wdata,
    output logic                 h_rsp_valid,
    output logic [DATA_W-1:0]    h_rsp_rdata,
    output logic                 i_req_valid,
    input  logic                 i_req_ready,
    output logic                 i_req_write,
    output logic [IADDR_W-1:0]   i_req_addr,
    output logic [DATA_W-1:0]    i_req_wdata,
    input  logic                 i_rsp_valid,
    input  logic [DATA_W-1:0]    i_rsp_rdata
);
    xl_regs_s               r_d, r_q;
    logic [WIN_W-1:0]       h_win;
    logic [OFS_W-1:0]       h_ofs;
    logic [PAGE_W-1:0]      cur_page;
    logic                   accept;
    logic                   local_hit;
    logic                   map_we;
    logic [DATA_W-1:0]      map_rdata;
    logic                   map_en;
    logic [NMAP*PAGE_W-1:0] map_pages;

    assign h_win = h_req_addr[OFS_W +: WIN_W];
    assign h_ofs = h_req_addr[OFS_W-1:0];

    pgwin_map_reg u_map_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (map_we),
        .wdata     (h_req_wdata),
        .rdata     (map_rdata),
        .map_en    (map_en),
        .map_pages (map_pages)
    );

    pgwin_page_map u_page_map (
        .map_en    (map_en),
        .map_pages (map_pages),
        .win       (h_win),
        .page      (cur_page)
    );

    always_comb begin
        r_d         = r_q;
        h_req_ready = (r_q.st == ST_IDLE);
        accept      = h_req_valid && h_req_ready;
        local_hit   = (h_win == '0) && (h_ofs == MAPREG_OFS);
        map_we      = accept && local_hit && h_req_write;
        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (local_hit) begin
                        r_d.st = ST_LOCAL;
                    end else begin
                        r_d.st    = ST_ISSUE;
                        r_d.wr    = h_req_write;
                        r_d.addr  = {cur_page, h_ofs};
                        r_d.wdata = h_req_wdata;
                    end
                end
            end
            ST_ISSUE: if (i_req_ready) r_d.st = ST_WAIT;
            ST_WAIT:  if (i_rsp_valid) r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, wr: 1'b0, addr: '0, wdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign i_req_valid = (r_q.st == ST_ISSUE);
    assign i_req_write = r_q.wr;
    assign i_req_addr  = r_q.addr;
    assign i_req_wdata = r_q.wdata;
    assign h_rsp_valid = ((r_q.st == ST_WAIT) && i_rsp_valid) || (r_q.st == ST_LOCAL);
    assign h_rsp_rdata = (r_q.st == ST_LOCAL) ? map_rdata : i_rsp_rdata;

    // R7: forwarded request goes out on the next cycle
    a_r7_issue_next: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req_valid && h_req_ready && !local_hit) |=> i_req_valid);

    // R7, R10: a stalled request keeps its address and payload
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req_valid && !i_req_ready) |=>
        (i_req_valid && $stable(i_req_addr) && $stable(i_req_wdata) && $stable(i_req_write)));

    // R6: the mapping register access stays local and answers next cycle
    a_r6_local_only: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req_valid && h_req_ready && local_hit) |=> (!i_req_valid && h_rsp_valid));

    // R9: no new acceptance while a transaction is open
    a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req_valid || h_rsp_valid) |-> !h_req_ready);

    // R2: window 0 resolves to page 0
    a_r2_win0_page0: assert property (@(posedge clk) disable iff (!rst_n)
        (h_win == '0) |-> (cur_page == '0));

    // R4: disabled mapping resolves every window to page 0
    a_r4_off_page0: assert property (@(posedge clk) disable iff (!rst_n)
        (!map_en) |-> (cur_page == '0));

    // R8: a forwarded response passes through in the same beat
    a_r8_same_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (i_rsp_valid && !h_req_ready && !i_req_valid) |-> (h_rsp_valid && h_rsp_rdata == i_rsp_rdata));
endmodule

// File: tb/pgwin_xlate_test.sv
module pgwin_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req_valid = 1'b0;
    logic        h_req_ready;
    logic        h_req_write = 1'b0;
    logic [31:0] h_req_addr = '0;
    logic [31:0] h_req_wdata = '0;
    logic        h_rsp_valid;
    logic [31:0] h_rsp_rdata;
    logic        i_req_valid;
    logic        i_req_ready = 1'b1;
    logic        i_req_write;
    logic [24:0] i_req_addr;
    logic [31:0] i_req_wdata;
    logic        i_rsp_valid = 1'b0;
    logic [31:0] i_rsp_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int rsp_cnt = 0;
    int cyc = 0;
    bit slow = 1'b0;
    bit pend = 1'b0;
    logic [24:0] paddr;
    logic [31:0] map_m = '0;

    logic [57:0] iq [$];
    string       itag [$];
    logic [32:0] rq [$];
    string       rtag [$];

    always #2.5 clk = ~clk;

    pgwin_xlate uut (.*);

    function automatic logic [31:0] mem_val(input logic [24:0] a);
        return {7'h35, a};
    endfunction

    function automatic logic [5:0] page_of(input logic [1:0] w);
        if (w == 2'd0 || !map_m[30]) return 6'd0;
        return map_m[6*(w-1) +: 6];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // internal-bus responder
    always @(negedge clk) begin
        cyc++;
        i_rsp_valid = 1'b0;
        if (pend) begin
            i_rsp_valid = 1'b1;
            i_rsp_rdata = mem_val(paddr);
            pend = 1'b0;
        end
        i_req_ready = !(slow && (cyc % 3 != 0));
        if (i_req_valid && i_req_ready) begin
            pend  = 1'b1;
            paddr = i_req_addr;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && i_req_valid && i_req_ready) begin
            if (iq.size() == 0) check(0, "R7 unexpected internal request", {39'd0, i_req_addr}, 0);
            else begin
                logic [57:0] e;
                string t;
                e = iq.pop_front();
                t = itag.pop_front();
                check({i_req_write, i_req_addr, i_req_wdata} == e, t,
                      {6'd0, i_req_write, i_req_addr, i_req_wdata}, {6'd0, e});
            end
        end
        if (rst_n && h_rsp_valid) begin
            if (rq.size() == 0) check(0, "R9 unexpected response", {32'd0, h_rsp_rdata}, 0);
            else begin
                logic [32:0] e;
                string t;
                e = rq.pop_front();
                t = rtag.pop_front();
                if (e[32]) check(h_rsp_rdata == e[31:0], t, {32'd0, h_rsp_rdata}, {32'd0, e[31:0]});
            end
            rsp_cnt++;
        end
    end

    task automatic host_op(input bit w, input logic [31:0] a, input logic [31:0] wd, input string tag);
        int target;
        bit local_acc;
        logic [24:0] ia;
        @(negedge clk);
        while (!h_req_ready) @(negedge clk);
        local_acc = (a[20:19] == 2'd0) && (a[18:0] == 19'h0310C);
        if (local_acc) begin
            if (w) map_m = wd & 32'h4003FFFF;
            rq.push_back({1'b1, map_m});
            rtag.push_back({tag, " map-reg readback"});
        end else begin
            ia = {page_of(a[20:19]), a[18:0]};
            iq.push_back({w, ia, wd});
            itag.push_back({tag, " internal request"});
            rq.push_back({!w, mem_val(ia)});
            rtag.push_back({tag, " response data"});
        end
        target = rsp_cnt + 1;
        h_req_valid = 1'b1;
        h_req_write = w;
        h_req_addr  = a;
        h_req_wdata = wd;
        @(negedge clk);
        h_req_valid = 1'b0;
        if (!local_acc) begin
            #1;
            check(i_req_valid == 1'b1, {tag, " R7 request next cycle"}, {63'd0, i_req_valid}, 1);
        end
        while (rsp_cnt < target) @(negedge clk);
    endtask

    // watchdog
    initial begin
        #(5 * 20000);
        check(0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(h_req_ready == 1'b1, "R1 ready after reset", {63'd0, h_req_ready}, 1);
        check(i_req_valid == 1'b0, "R1 no internal request", {63'd0, i_req_valid}, 0);
        check(h_rsp_valid == 1'b0, "R1 no response", {63'd0, h_rsp_valid}, 0);
        host_op(0, 32'h0000_310C, 0, "R1 map reg reset value");

        // all windows page 0 after reset, R4
        host_op(0, 32'h0008_0040, 0, "R4 win1 disabled");
        host_op(1, 32'h0018_1234, 32'hCAFE_0001, "R4 win3 disabled write");

        // program pages but leave disabled, R4
        host_op(1, 32'h0000_310C, 32'h0003_4C91, "R4 program off");
        host_op(0, 32'h0010_0008, 0, "R4 win2 still page0");

        // enable with distinct fields, R3 / R6 unused bits
        host_op(1, 32'h0000_310C, 32'hFFFF_FFFF, "R6 unused bits");
        host_op(1, 32'h0000_310C, 32'h4000_0000 | (32'h33 << 12) | (32'h22 << 6) | 32'h11, "R3 program");
        host_op(0, 32'h0008_0004, 0, "R3 win1");
        host_op(0, 32'h0010_7FFC, 0, "R3 win2");
        host_op(1, 32'h0018_0100, 32'h1234_5678, "R3 win3 write");
        host_op(0, 32'h0000_0200, 0, "R2 win0 ignores map");
        host_op(0, 32'h0000_310C, 0, "R6 readback");

        // upper host bits ignored, R5
        host_op(0, 32'hFFE8_0ABC, 0, "R5 upper bits win1");
        host_op(0, 32'h5A5F_FFFF, 0, "R5 max offset win3");

        // remap then use at once, R10
        host_op(1, 32'h0000_310C, 32'h4000_0000 | (32'h3F << 6) | 32'h01, "R10 remap");
        host_op(0, 32'h0010_0010, 0, "R10 win2 new page");
        host_op(0, 32'h0018_0010, 0, "R10 win3 new page");

        // stalled internal side, R7 / R8 / R10
        slow = 1'b1;
        host_op(0, 32'h0008_1110, 0, "R8 stalled read");
        host_op(1, 32'h0010_2220, 32'hA5A5_5A5A, "R7 stalled write");
        host_op(0, 32'h0000_0004, 0, "R2 stalled win0");
        slow = 1'b0;

        // disable again, R4
        host_op(1, 32'h0000_310C, 32'h0000_0FFF, "R4 disable");
        host_op(0, 32'h0008_0000, 0, "R4 win1 back to page0");

        repeat (3) @(negedge clk);
        check(iq.size() == 0 && rq.size() == 0, "R9 all expectations consumed",
              {32'(iq.size()), 32'(rq.size())}, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule